// File: doc/BRIEF.md
# Loop Frequency Setting Register with Feedback Divider

This block keeps the two frequency settings of a clock multiplier loop in one byte-wide register that a host bus can read and write. The upper nibble selects the feedback divide ratio N, and the lower nibble selects the VCO centre-of-range multiplier L. Both fields come out of reset at 6. While the loop-enable input is high, bus writes are refused. The stored value can still be read back at any time.

The block also contains the modulo feedback counter. It counts VCO-rate enable ticks and gives a one-cycle feedback pulse once every N ticks. A multiplier code of zero divides by one, the same as code one. When the range field holds zero, the block drives a loop-disable output. It also sends a one-cycle request to the control logic to clear the base clock select bit.

Top module: `pll_prog_reg`

## Requirements
- R1: Synchronous active-low reset loads 0x66 into the register, clears the feedback counter, and drives fb_pulse and bcs_clr low.
- R2: A write with wr_en=1 while loop_on=0 stores wr_data (multiplier code in bits 7:4, range code in bits 3:0). rd_data shows the new value in the cycle after the write edge.
- R3: A write while loop_on=1 leaves the multiplier code (rd_data bits 7:4) unchanged. It also leaves the feedback counter phase unchanged.
- R4: A write while loop_on=1 leaves the range code (rd_data bits 3:0) unchanged.
- R5: With multiplier code N from 1 to 15, fb_pulse is high for exactly one cycle, in the cycle after every N-th vco_tick. It stays low otherwise.
- R6: Multiplier code 0 divides by 1. Every vco_tick gives a pulse, so back-to-back ticks hold fb_pulse high.
- R7: loop_kill is high exactly while the stored range code is 0.
- R8: bcs_clr is high for one cycle, in the cycle after an accepted write that stores range code 0. A refused write never raises it. It also pulses after reset release if the reset range value is 0.
- R9: Every accepted write restarts the feedback count from zero. The next pulse then follows the N-th tick after the write.
- R10: div_n shows the divide ratio in effect: the multiplier code, or 1 when the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Stored register value |
| loop_on | input | 1 | Loop enabled; locks the register |
| vco_tick | input | 1 | VCO-rate count enable |
| fb_pulse | output | 1 | One-cycle feedback pulse |
| div_n | output | 4 | Divide ratio in effect |
| loop_kill | output | 1 | Forces the loop off (range code 0) |
| bcs_clr | output | 1 | Request to clear base clock select |

## Verification
Register contents, div_n and loop_kill change at the write edge. fb_pulse and bcs_clr are registered at the edge that takes the tick or the write. So every result is due one cycle after its stimulus. The bench applies each stimulus at a falling edge, lets one rising edge pass, and samples at the next falling edge. The tick scenarios put an idle cycle between ticks, so each sample belongs to exactly one tick. The back-to-back case checks that fb_pulse stays high on every cycle and falls one cycle after the ticks stop.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

    localparam int          FIELD_W   = 4;
    localparam int          REG_W     = 2 * FIELD_W;
    localparam logic [3:0]  MULT_RST  = 4'd6;
    localparam logic [3:0]  RANGE_RST = 4'd6;

endpackage

// File: rtl/pll_lock_field.sv
module pll_lock_field #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic         lock,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         take
);

    typedef struct packed {
        logic [W-1:0] val;
    } field_t;

    field_t fld_d, fld_q;

    assign take = wr_stb & ~lock;

    always_comb begin
        fld_d = fld_q;
        if (!rst_n) begin
            fld_d.val = RST_VAL;
        end else if (take) begin
            fld_d.val = wdata;
        end
    end

    always_ff @(posedge clk) begin
        fld_q <= fld_d;
    end

    assign q = fld_q.val;

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && rst_n) |=> $stable(q)); // R3

    AST_OPEN_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !lock && rst_n) |=> (q == $past(wdata))); // R2

endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] code,
    output logic [W-1:0] div_n,
    output logic         fb_pulse
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } div_t;

    div_t dv_d, dv_q;
    logic [W-1:0] n_eff;
    logic         at_last;

    always_comb begin
        n_eff   = (code == '0) ? W'(1) : code;
        at_last = (dv_q.cnt >= (n_eff - W'(1)));
        dv_d       = dv_q;
        dv_d.pulse = 1'b0;
        if (!rst_n) begin
            dv_d = '0;
        end else if (restart) begin
            dv_d.cnt = '0;
        end else if (tick) begin
            if (at_last) begin
                dv_d.cnt   = '0;
                dv_d.pulse = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        dv_q <= dv_d;
    end

    assign div_n    = n_eff;
    assign fb_pulse = dv_q.pulse;

    AST_CNT_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.cnt < div_n); // R5

    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && $past(rst_n)) |-> $past(tick)); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && rst_n) |=> !fb_pulse); // R9

endmodule

// File: rtl/pll_range_guard.sv
module pll_range_guard #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] range_q,
    input  logic         take,
    input  logic [W-1:0] wr_range,
    output logic         loop_kill,
    output logic         bcs_clr
);

    typedef struct packed {
        logic in_rst;
        logic clr;
    } grd_t;

    grd_t g_d, g_q;

    always_comb begin
        g_d.in_rst = ~rst_n;
        g_d.clr    = rst_n &&
                     ((take && (wr_range == '0)) ||
                      (g_q.in_rst && !take && (range_q == '0)));
    end

    always_ff @(posedge clk) begin
        g_q <= g_d;
    end

    assign loop_kill = (range_q == '0);
    assign bcs_clr   = g_q.clr;

    AST_CLR_WITH_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        bcs_clr |-> loop_kill); // R8

    AST_ZERO_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rst_n && (wr_range == '0)) |=> (loop_kill && bcs_clr)); // R7

endmodule

// File: rtl/pll_prog_reg.sv
module pll_prog_reg
    import pll_prog_pkg::*;
#(
    parameter int              FW        = FIELD_W,
    parameter logic [FW-1:0]   MULT_INIT = MULT_RST,
    parameter logic [FW-1:0]   RANGE_INIT = RANGE_RST,
    localparam int             RW        = 2 * FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    input  logic          loop_on,
    input  logic          vco_tick,
    output logic          fb_pulse,
    output logic [FW-1:0] div_n,
    output logic          loop_kill,
    output logic          bcs_clr
);

    logic [FW-1:0] mult_q, range_q;
    logic          mult_take, range_take;

    pll_lock_field #(.W(FW), .RST_VAL(MULT_INIT)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_en),
        .lock   (loop_on),
        .wdata  (wr_data[RW-1:FW]),
        .q      (mult_q),
        .take   (mult_take)
    );

    pll_lock_field #(.W(FW), .RST_VAL(RANGE_INIT)) u_range (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_en),
        .lock   (loop_on),
        .wdata  (wr_data[FW-1:0]),
        .q      (range_q),
        .take   (range_take)
    );

    pll_fb_div #(.W(FW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (vco_tick),
        .restart  (mult_take),
        .code     (mult_q),
        .div_n    (div_n),
        .fb_pulse (fb_pulse)
    );

    pll_range_guard #(.W(FW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_q   (range_q),
        .take      (range_take),
        .wr_range  (wr_data[FW-1:0]),
        .loop_kill (loop_kill),
        .bcs_clr   (bcs_clr)
    );

    assign rd_data = {mult_q, range_q};

    AST_TAKES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        mult_take == range_take); // R2

    AST_LOCK_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && rst_n) |=> $stable(rd_data)); // R4

endmodule

// File: tb/test_pll_prog_reg.sv
module test_pll_prog_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       loop_on = 1'b0;
    logic       vco_tick = 1'b0;
    logic [7:0] rd_data;
    logic       fb_pulse;
    logic [3:0] div_n;
    logic       loop_kill;
    logic       bcs_clr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pll_prog_reg i_pll_prog_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .loop_on   (loop_on),
        .vco_tick  (vco_tick),
        .fb_pulse  (fb_pulse),
        .div_n     (div_n),
        .loop_kill (loop_kill),
        .bcs_clr   (bcs_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // write at a falling edge, one rising edge, results sampled at the next falling edge
    task automatic bus_write(input logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // one tick, then an idle cycle; returns fb_pulse seen in the cycle after the tick
    task automatic one_tick(output logic p);
        @(negedge clk);
        vco_tick = 1'b1;
        @(negedge clk);
        vco_tick = 1'b0;
        p = fb_pulse;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h66);
        chk("R1 fb_pulse", fb_pulse, 0);
        chk("R1 bcs_clr", bcs_clr, 0);
        chk("R7 loop_kill at reset", loop_kill, 0);
        chk("R10 div_n at reset", div_n, 6);
    endtask

    task automatic t_open_write;
        bus_write(8'h3A);
        chk("R2 rd_data", rd_data, 8'h3A);
        chk("R10 div_n", div_n, 3);
        chk("R8 no clr on nonzero", bcs_clr, 0);
    endtask

    task automatic t_locked_write;
        loop_on = 1'b1;
        bus_write(8'hF0);
        chk("R3 mult kept", rd_data[7:4], 4'h3);
        chk("R4 range kept", rd_data[3:0], 4'hA);
        chk("R8 no clr when locked", bcs_clr, 0);
        chk("R7 loop_kill low", loop_kill, 0);
        loop_on = 1'b0;
    endtask

    task automatic t_divide(input logic [7:0] val, input int n);
        logic p;
        bus_write(val);
        for (int i = 1; i <= 3 * n + 1; i++) begin
            one_tick(p);
            chk($sformatf("R5 N=%0d tick %0d", n, i), p, (i % n) == 0);
        end
    endtask

    task automatic t_code_zero;
        bus_write(8'h05);
        chk("R10 code0 div_n", div_n, 1);
        @(negedge clk);
        vco_tick = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6 back-to-back", fb_pulse, 1);
        end
        vco_tick = 1'b0;
        @(negedge clk);
        chk("R6 drop after last", fb_pulse, 0);
    endtask

    task automatic t_restart;
        logic p;
        bus_write(8'h45);
        one_tick(p);
        one_tick(p);
        bus_write(8'h45);
        for (int i = 1; i <= 4; i++) begin
            one_tick(p);
            chk($sformatf("R9 restart tick %0d", i), p, i == 4);
        end
        one_tick(p);
        one_tick(p);
        loop_on = 1'b1;
        bus_write(8'h45);
        loop_on = 1'b0;
        one_tick(p);
        chk("R3 phase kept tick 1", p, 0);
        one_tick(p);
        chk("R3 phase kept tick 2", p, 1);
    endtask

    task automatic t_range_zero;
        bus_write(8'h51);
        loop_on = 1'b1;
        bus_write(8'h50);
        chk("R8 locked zero no clr", bcs_clr, 0);
        chk("R4 range still 1", rd_data[3:0], 4'h1);
        chk("R7 kill low", loop_kill, 0);
        loop_on = 1'b0;
        bus_write(8'h50);
        chk("R8 clr pulse", bcs_clr, 1);
        chk("R7 kill high", loop_kill, 1);
        chk("R2 rd zero range", rd_data, 8'h50);
        @(negedge clk);
        chk("R8 clr one cycle", bcs_clr, 0);
        chk("R7 kill stays", loop_kill, 1);
        bus_write(8'h52);
        chk("R7 kill released", loop_kill, 0);
        chk("R8 no clr on release", bcs_clr, 0);
    endtask

    initial begin
        t_reset();
        t_open_write();
        t_locked_write();
        t_divide(8'h36, 3);
        t_divide(8'h16, 1);
        t_divide(8'hF6, 15);
        t_code_zero();
        t_restart();
        t_range_zero();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule